// File: doc/BRIEF.md
# Content-Directed Pointer Prefetcher

This block sits beside a cache fill path and looks at the data in each line as it arrives from memory. Any 32-bit word in the line that looks like a virtual address is treated as a likely pointer. A word looks like an address when its most significant bits equal the same bits of the address of the line being filled. Each such pointer becomes a prefetch request for the cache block it points into. Linked structures can then be fetched one hop ahead without any history of earlier misses.

A fill is presented for one cycle with its line address and all eight words. All words are examined in parallel. The qualifying words are written, lowest word first, into a small request queue in that same cycle. A memory-side consumer drains the queue through a valid/ready handshake. A configuration input selects how many upper address bits take part in the comparison.

Top module: `ptr_prefetch`

## Requirements
- R1: After reset, and until a fill has produced a candidate, pfValid is low.
- R2: A word qualifies when its top cmpBits bits equal the top cmpBits bits of fillAddr. Its request address is the word with its low 5 bits cleared, for a 32-byte block. cmpBits = 0 compares no bits, and cmpBits = 32 requires full equality.
- R3: A word whose value is zero never produces a request.
- R4: A word whose block address (bits 31:5) equals that of fillAddr never produces a request.
- R5: Requests from one fill come out in ascending word order. Word 0 is fillData[31:0] and word 7 is fillData[255:224].
- R6: The queue holds 8 requests. Free space is the number of empty entries at the start of the fill cycle; a pop in that same cycle does not add space. When a fill has more candidates than free entries, the lowest-numbered candidates are kept and the rest are dropped.
- R7: While pfValid is high and pfReady is low, pfValid stays high and pfAddr holds its value. A request leaves the queue on a cycle with pfValid and pfReady both high.
- R8: A request from a fill sampled at a clock edge is visible on pfValid/pfAddr right after that edge when the queue was empty.
- R9: With fillValid low, nothing is queued, whatever fillData holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fillValid | input | 1 | Fill line present this cycle |
| fillAddr | input | 32 | Address of the line being filled |
| fillData | input | 256 | Eight 32-bit words of the line, word 0 in the low bits |
| cmpBits | input | 6 | Number of upper address bits compared (0 to 32) |
| pfValid | output | 1 | A prefetch request is available |
| pfReady | input | 1 | Consumer accepts the request |
| pfAddr | output | 32 | Block-aligned prefetch address |

## Verification
A wrong occupancy count or pointer shows up at the ports within one drain. It appears as a missing, repeated or out-of-order address, or as pfValid staying high or dropping early. A wrong compare mask or a bad suppression rule changes the set of addresses that come out of the very next fill. The overflow cases push a full fill into a partly full queue and a fill into a full queue that is popped in the same cycle. Both reveal an off-by-one in the free-space count by the length of the drained list.

// File: rtl/ptrpf_pkg.sv
`timescale 1ns/1ps
package ptrpf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;  // write accepted candidates this cycle
    logic pop;   // head entry leaves this cycle
  } ptrpf_strobe_t;
endpackage

// File: rtl/ptrpf_dp.sv
`timescale 1ns/1ps
module ptrpf_dp
  import ptrpf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8,
  parameter int DEPTH  = 8,
  parameter int OFF_W  = 5,
  localparam int CB_W  = $clog2(ADDR_W + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int WC_W  = $clog2(WORDS + 1)
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       fillAddr,
  input  logic [WORDS*ADDR_W-1:0] fillData,
  input  logic [CB_W-1:0]         cmpBits,
  input  ptrpf_strobe_t           strobe,
  input  logic [PTR_W-1:0]        wrPtr,
  input  logic [PTR_W-1:0]        rdPtr,
  input  logic [OCC_W-1:0]        freeSlots,
  output logic [WC_W-1:0]         candCount,
  output logic [ADDR_W-1:0]       headAddr
);
  logic [ADDR_W-1:0] slotMem [DEPTH];
  logic [ADDR_W-1:0] cmpMask;
  logic [CB_W-1:0]   shAmt;
  logic [WORDS-1:0]  cand;
  logic [WC_W-1:0]   rank [WORDS];
  logic [ADDR_W-1:0] alignedWord [WORDS];

  always_comb begin
    if (int'(cmpBits) >= ADDR_W) shAmt = '0;
    else shAmt = CB_W'(ADDR_W) - cmpBits;
    cmpMask = {ADDR_W{1'b1}} << shAmt;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [ADDR_W-1:0] wordVal;
    assign wordVal = fillData[w*ADDR_W +: ADDR_W];
    assign alignedWord[w] = {wordVal[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign cand[w] = (((wordVal ^ fillAddr) & cmpMask) == '0)
                   && (wordVal != '0)
                   && (wordVal[ADDR_W-1:OFF_W] != fillAddr[ADDR_W-1:OFF_W]);
  end

  always_comb begin
    logic [WC_W-1:0] running;
    running = '0;
    for (int w = 0; w < WORDS; w++) begin
      rank[w] = running;
      if (cand[w]) running = running + WC_W'(1);
    end
    candCount = running;
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      for (int w = 0; w < WORDS; w++) begin
        if (cand[w] && (int'(rank[w]) < int'(freeSlots)))
          slotMem[wrPtr + PTR_W'(rank[w])] <= alignedWord[w];
      end
    end
  end

  assign headAddr = slotMem[rdPtr];
endmodule

// File: rtl/ptrpf_ctl.sv
`timescale 1ns/1ps
module ptrpf_ctl
  import ptrpf_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int WC_W  = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fillValid,
  input  logic             pfReady,
  input  logic [WC_W-1:0]  candCount,
  output ptrpf_strobe_t    strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [OCC_W-1:0] freeSlots,
  output logic             notEmpty
);
  logic [OCC_W-1:0] occ;
  int acceptN;

  assign freeSlots = OCC_W'(DEPTH) - occ;
  assign notEmpty  = (occ != '0);
  assign strobe.push = fillValid;
  assign strobe.pop  = notEmpty && pfReady;

  always_comb begin
    acceptN = 0;
    if (fillValid)
      acceptN = (int'(candCount) > int'(freeSlots)) ? int'(freeSlots) : int'(candCount);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ   <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      occ   <= OCC_W'(int'(occ) + acceptN - (strobe.pop ? 1 : 0));
      wrPtr <= wrPtr + PTR_W'(acceptN);
      if (strobe.pop) rdPtr <= rdPtr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/ptr_prefetch.sv
`timescale 1ns/1ps
module ptr_prefetch
  import ptrpf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8,
  parameter int DEPTH  = 8,
  parameter int OFF_W  = 5,
  localparam int CB_W  = $clog2(ADDR_W + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int WC_W  = $clog2(WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fillValid,
  input  logic [ADDR_W-1:0]       fillAddr,
  input  logic [WORDS*ADDR_W-1:0] fillData,
  input  logic [CB_W-1:0]         cmpBits,
  output logic                    pfValid,
  input  logic                    pfReady,
  output logic [ADDR_W-1:0]       pfAddr
);
  ptrpf_strobe_t    strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] freeSlots;
  logic [WC_W-1:0]  candCount;

  ptrpf_ctl #(.WORDS(WORDS), .DEPTH(DEPTH)) i_ctl (
    .clk(clk), .rst(rst), .fillValid(fillValid), .pfReady(pfReady),
    .candCount(candCount), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .freeSlots(freeSlots), .notEmpty(pfValid)
  );

  ptrpf_dp #(.ADDR_W(ADDR_W), .WORDS(WORDS), .DEPTH(DEPTH), .OFF_W(OFF_W)) i_dp (
    .clk(clk), .fillAddr(fillAddr), .fillData(fillData), .cmpBits(cmpBits),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .freeSlots(freeSlots),
    .candCount(candCount), .headAddr(pfAddr)
  );
endmodule

module ptrpf_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              fillValid,
  input logic              pfValid,
  input logic              pfReady,
  input logic [ADDR_W-1:0] pfAddr
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> !pfValid);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pfValid && !pfReady) |=> (pfValid && $stable(pfAddr)));

  // R2
  block_align_chk: assert property (@(posedge clk) disable iff (rst)
    pfValid |-> (pfAddr[OFF_W-1:0] == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!fillValid && !pfValid) |=> !pfValid);
endmodule

bind ptr_prefetch ptrpf_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst(rst), .fillValid(fillValid),
  .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr)
);

// File: tb/test_ptr_prefetch.sv
`timescale 1ns/1ps
module test_ptr_prefetch;
  typedef struct packed {
    logic [31:0]  addr;
    logic [255:0] data;
    logic [5:0]   bits;
    logic [3:0]   expCnt;
  } vec_t;

  localparam logic [255:0] DATA_SEQ8 = {32'h40000200, 32'h400001C0, 32'h40000180, 32'h40000140,
                                        32'h40000100, 32'h400000C0, 32'h40000080, 32'h40000040};
  localparam logic [255:0] DATA_SEQ5 = {32'h0, 32'h0, 32'h0, 32'h40000140,
                                        32'h40000100, 32'h400000C0, 32'h40000080, 32'h40000040};
  localparam logic [255:0] DATA_B8   = {32'h50000200, 32'h500001C0, 32'h50000180, 32'h50000140,
                                        32'h50000100, 32'h500000C0, 32'h50000080, 32'h50000040};

  localparam vec_t VECS [5] = '{
    '{32'h40001000, {32'h400ABCDE, 32'h3FF00000, 32'h40001020, 32'h400FFFFC,
                     32'h40001010, 32'h50000000, 32'h0, 32'h40012344}, 6'd12, 4'd4},
    '{32'h40000000, DATA_SEQ8, 6'd12, 4'd8},
    '{32'h10000000, {32'h0, 32'h0, 32'h0, 32'h0, 32'h7, 32'h10000008, 32'hFFFFFFE0, 32'h0}, 6'd0, 4'd2},
    '{32'h20000040, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h20000044, 32'h20000040}, 6'd32, 4'd0},
    '{32'hA0000000, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hA1234567, 32'hB0000000, 32'hAFFFFFFF}, 6'd4, 4'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fillValid = 1'b0;
  logic [31:0] fillAddr = '0;
  logic [255:0] fillData = '0;
  logic [5:0] cmpBits = 6'd12;
  logic pfValid;
  logic pfReady = 1'b0;
  logic [31:0] pfAddr;

  int checks = 0;
  int failures = 0;
  logic [31:0] expList [16];
  int expN;

  always #4 clk = ~clk;

  ptr_prefetch i_ptr_prefetch (
    .clk(clk), .rst(rst), .fillValid(fillValid), .fillAddr(fillAddr),
    .fillData(fillData), .cmpBits(cmpBits), .pfValid(pfValid),
    .pfReady(pfReady), .pfAddr(pfAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference from the requirements: appends qualifying block addresses
  task automatic modelAppend(input logic [31:0] a, input logic [255:0] d, input int bits, input int limit);
    int taken = 0;
    for (int w = 0; w < 8; w++) begin
      logic [31:0] v = d[w*32 +: 32];
      int sh = 32 - bits;
      bit topEq = ((v >> sh) == (a >> sh));
      if (bits == 0) topEq = 1'b1;
      if (topEq && v != 0 && (v >> 5) != (a >> 5) && taken < limit) begin
        expList[expN] = v & 32'hFFFFFFE0;
        expN++;
        taken++;
      end
    end
  endtask

  task automatic applyFill(input logic [31:0] a, input logic [255:0] d, input logic [5:0] bits);
    fillAddr = a; fillData = d; cmpBits = bits; fillValid = 1'b1;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  // called at a negedge; drains the queue and compares against expList
  task automatic drain(input string req);
    int got = 0;
    pfReady = 1'b1;
    for (int k = 0; k < 12; k++) begin
      if (!pfValid) break;
      if (got < expN) check(pfAddr == expList[got], req, pfAddr, expList[got]);
      got++;
      @(negedge clk);
    end
    check(got == expN, {req, " count"}, 32'(got), 32'(expN));
    pfReady = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pfValid == 1'b0, "R1 in reset", 32'(pfValid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(pfValid == 1'b0, "R1 after reset", 32'(pfValid), 32'd0);

    // table walk: R2 R3 R4 R5 R8
    foreach (VECS[i]) begin
      expN = 0;
      modelAppend(VECS[i].addr, VECS[i].data, int'(VECS[i].bits), 8);
      check(expN == int'(VECS[i].expCnt), "R2 table model count", 32'(expN), 32'(VECS[i].expCnt));
      applyFill(VECS[i].addr, VECS[i].data, VECS[i].bits);
      drain($sformatf("R5 vector %0d", i));
    end

    // R9: data present but fillValid low
    fillAddr = 32'h40000000; fillData = DATA_SEQ8; cmpBits = 6'd12;
    repeat (3) @(negedge clk);
    check(pfValid == 1'b0, "R9 no fill no request", 32'(pfValid), 32'd0);

    // R7: stall holds head
    applyFill(32'h40000000, DATA_SEQ8, 6'd12);
    for (int k = 0; k < 3; k++) begin
      check(pfValid && pfAddr == 32'h40000040, "R7 stall hold", pfAddr, 32'h40000040);
      @(negedge clk);
    end
    expN = 0;
    modelAppend(32'h40000000, DATA_SEQ8, 12, 8);
    drain("R7 after stall");

    // R6: 5 queued, then 8 more -> only 3 lowest kept
    expN = 0;
    modelAppend(32'h40000000, DATA_SEQ5, 12, 8);
    modelAppend(32'h50000000, DATA_B8, 12, 3);
    applyFill(32'h40000000, DATA_SEQ5, 6'd12);
    applyFill(32'h50000000, DATA_B8, 6'd12);
    drain("R6 partial overflow");

    // R6: full queue, pop and fill in same cycle -> fill dropped
    applyFill(32'h40000000, DATA_SEQ8, 6'd12);
    pfReady = 1'b1;
    applyFill(32'h50000000, DATA_B8, 6'd12);
    expN = 0;
    modelAppend(32'h40000000, DATA_SEQ8, 12, 8);
    for (int k = 0; k < 7; k++) expList[k] = expList[k + 1];
    expN = 7;
    drain("R6 full with pop");

    // R1: reset clears a non-empty queue
    applyFill(32'h40000000, DATA_SEQ8, 6'd12);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(pfValid == 1'b0, "R1 reset flush", 32'(pfValid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule